// File: doc/BRIEF.md
# Instruction Fetch Front End with Static Branch Prediction

This block is the front end of a four-stage pipeline. It keeps a program counter, issues fetch addresses to an instruction memory, and places each returned instruction, with its address, into a small in-order queue that the decode stage drains at its own pace. Fetch therefore runs ahead of decode until the queue is full.

Branch prediction is static. For each branch that decode presents, the block returns a taken/not-taken prediction. An unconditional branch is always taken. A compiler hint bit in the instruction, when it is present, decides the outcome. Otherwise a mode input picks the policy: either always not taken, or taken for a backward target and not taken for a forward one. A branch predicted taken redirects fetch from decode, and the queued wrong-path work is dropped. Execute later reports each conditional branch's real outcome. On a mismatch, the queue is emptied, decode's instruction is killed, and fetch restarts one cycle later at the correct address. Until such a branch resolves, a speculation flag tells later stages not to commit results.

Top module: `fetch_unit`

## Requirements
- R1: After reset, imem_addr equals RESET_PC (default 0x100), q_valid is 0 and spec_active is 0.
- R2: In each cycle with imem_req and imem_gnt both high, the word on imem_rdata is queued with the address imem_addr, and imem_addr advances by 4. imem_req drops while the queue holds DEPTH (default 4) entries.
- R3: With pred_mode = 0 and dec_hint_en = 0, a conditional branch gives dec_pred_taken = 0 for either target direction.
- R4: With pred_mode = 1 and dec_hint_en = 0, a conditional branch gives dec_pred_taken = 1 when dec_target < dec_pc (unsigned compare) and 0 otherwise, including when the two are equal.
- R5: For a conditional branch with dec_hint_en = 1, dec_pred_taken equals dec_hint in either mode.
- R6: With dec_br_uncond = 1, dec_pred_taken is 1 whatever the mode and hint.
- R7: When dec_br_valid and dec_pred_taken are high and there is no execute mispredict, q_valid is 0 in that cycle. In the next cycle the queue is empty and imem_addr equals dec_target.
- R8: When ex_valid is high and ex_taken differs from ex_pred_taken, flush_dec is 1 and q_valid is 0 in that cycle. In the next cycle the queue is empty and imem_addr equals ex_target if ex_taken is 1, or ex_pc + 4 otherwise. This redirect wins over a redirect from decode in the same cycle, and a correct prediction causes no flush.
- R9: spec_active rises the cycle after decode presents a conditional branch. It returns to 0 the cycle after ex_valid, unless a new conditional branch is presented in that same cycle.
- R10: While imem_gnt is 0, nothing is queued and imem_addr holds.
- R11: The queue delivers entries in fetch order, including when pushes and pops happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pred_mode | input | 1 | 0 = predict not taken, 1 = backward taken / forward not taken |
| imem_req | output | 1 | Fetch request this cycle |
| imem_addr | output | AW | Fetch address |
| imem_gnt | input | 1 | imem_rdata is valid for imem_addr this cycle |
| imem_rdata | input | IW | Fetched instruction word |
| q_valid | output | 1 | Queue head is valid |
| q_ready | input | 1 | Decode takes the queue head |
| q_instr | output | IW | Queue head instruction |
| q_pc | output | AW | Queue head address |
| dec_br_valid | input | 1 | Decode holds a branch this cycle |
| dec_br_uncond | input | 1 | That branch is unconditional |
| dec_hint_en | input | 1 | The branch carries a compiler hint |
| dec_hint | input | 1 | Hint value, 1 = taken |
| dec_pc | input | AW | Address of the branch in decode |
| dec_target | input | AW | Branch target computed in decode |
| dec_pred_taken | output | 1 | Prediction for the branch in decode |
| ex_valid | input | 1 | Execute resolves a conditional branch |
| ex_taken | input | 1 | Actual outcome |
| ex_pred_taken | input | 1 | Prediction that travelled with it |
| ex_pc | input | AW | Address of the resolving branch |
| ex_target | input | AW | Its taken target |
| flush_dec | output | 1 | Kill the instruction now in decode |
| spec_active | output | 1 | An unresolved conditional branch is in flight |

## Verification
A corrupted queue pointer or count appears at the next pop: q_pc stops stepping by 4 from the previous head, or q_instr no longer matches its address. A corrupted program counter appears on imem_addr in the very next cycle after a fetch or redirect, so every redirect is checked one edge later against the target or the fall-through address. A stale speculation flag or a missing flush appears on spec_active, flush_dec or q_valid within one cycle of the branch event.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;
    typedef enum logic {
        PM_NOT_TAKEN = 1'b0,
        PM_DIRECTION = 1'b1
    } pred_mode_e;
endpackage

// File: rtl/fu_predict.sv
`timescale 1ns/1ps
module fu_predict #(
    parameter int unsigned AW = 32
) (
    input  fetch_pkg::pred_mode_e mode,
    input  logic                  uncond,
    input  logic                  hint_en,
    input  logic                  hint,
    input  logic [AW-1:0]         br_pc,
    input  logic [AW-1:0]         br_target,
    output logic                  taken
);
    always_comb begin
        if (uncond)
            taken = 1'b1;
        else if (hint_en)
            taken = hint;
        else if (mode == fetch_pkg::PM_DIRECTION)
            taken = (br_target < br_pc);
        else
            taken = 1'b0;
    end
endmodule

// File: rtl/fu_queue.sv
`timescale 1ns/1ps
module fu_queue #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == FULL_CNT);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            if (do_pop)  st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= wdata;
    end
endmodule

// File: rtl/fetch_unit.sv
`timescale 1ns/1ps
module fetch_unit #(
    parameter int unsigned AW       = 32,
    parameter int unsigned IW       = 32,
    parameter int unsigned DEPTH    = 4,
    parameter logic [31:0] RESET_PC = 32'h0000_0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pred_mode,
    output logic          imem_req,
    output logic [AW-1:0] imem_addr,
    input  logic          imem_gnt,
    input  logic [IW-1:0] imem_rdata,
    output logic          q_valid,
    input  logic          q_ready,
    output logic [IW-1:0] q_instr,
    output logic [AW-1:0] q_pc,
    input  logic          dec_br_valid,
    input  logic          dec_br_uncond,
    input  logic          dec_hint_en,
    input  logic          dec_hint,
    input  logic [AW-1:0] dec_pc,
    input  logic [AW-1:0] dec_target,
    output logic          dec_pred_taken,
    input  logic          ex_valid,
    input  logic          ex_taken,
    input  logic          ex_pred_taken,
    input  logic [AW-1:0] ex_pc,
    input  logic [AW-1:0] ex_target,
    output logic          flush_dec,
    output logic          spec_active
);
    localparam int unsigned   EW  = IW + AW;
    localparam logic [AW-1:0] INC = AW'(IW / 8);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          spec;
    } fstate_t;

    fstate_t st_d, st_q;
    logic ex_miss, dec_redir, flush, q_empty, q_full, push;
    logic [AW-1:0] ex_fix_pc;
    logic [EW-1:0] q_rdata;

    fu_predict #(.AW(AW)) u_pred (
        .mode      (fetch_pkg::pred_mode_e'(pred_mode)),
        .uncond    (dec_br_uncond),
        .hint_en   (dec_hint_en),
        .hint      (dec_hint),
        .br_pc     (dec_pc),
        .br_target (dec_target),
        .taken     (dec_pred_taken)
    );

    fu_queue #(.DEPTH(DEPTH), .W(EW)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .wdata ({imem_rdata, st_q.pc}),
        .pop   (q_ready),
        .rdata (q_rdata),
        .empty (q_empty),
        .full  (q_full)
    );

    assign ex_miss   = ex_valid && (ex_taken != ex_pred_taken);
    assign ex_fix_pc = ex_taken ? ex_target : ex_pc + INC;
    assign dec_redir = dec_br_valid && dec_pred_taken && !ex_miss;
    assign flush     = ex_miss || dec_redir;

    assign imem_req    = !q_full && !flush;
    assign imem_addr   = st_q.pc;
    assign push        = imem_req && imem_gnt;
    assign q_valid     = !q_empty && !flush;
    assign q_instr     = q_rdata[EW-1:AW];
    assign q_pc        = q_rdata[AW-1:0];
    assign flush_dec   = ex_miss;
    assign spec_active = st_q.spec;

    always_comb begin
        st_d = st_q;
        if (ex_miss)        st_d.pc = ex_fix_pc;
        else if (dec_redir) st_d.pc = dec_target;
        else if (push)      st_d.pc = st_q.pc + INC;

        if (ex_valid) st_d.spec = 1'b0;
        if (dec_br_valid && !dec_br_uncond && !ex_miss) st_d.spec = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc   <= AW'(RESET_PC);
            st_q.spec <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fetch_unit_chk.sv
`timescale 1ns/1ps
module fetch_unit_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          imem_req,
    input logic [AW-1:0] imem_addr,
    input logic          imem_gnt,
    input logic          q_valid,
    input logic          dec_br_valid,
    input logic          dec_br_uncond,
    input logic          dec_hint_en,
    input logic          dec_hint,
    input logic [AW-1:0] dec_target,
    input logic          dec_pred_taken,
    input logic          ex_valid,
    input logic          ex_taken,
    input logic          ex_pred_taken,
    input logic [AW-1:0] ex_target,
    input logic          flush_dec,
    input logic          spec_active
);
    assert_uncond_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_br_valid && dec_br_uncond |-> dec_pred_taken);

    assert_hint_decides_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_br_valid && !dec_br_uncond && dec_hint_en |-> dec_pred_taken == dec_hint);

    assert_miss_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && (ex_taken != ex_pred_taken) |-> flush_dec && !q_valid);

    assert_miss_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_taken && !ex_pred_taken |=> !q_valid && imem_addr == $past(ex_target));

    assert_dec_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_br_valid && dec_pred_taken && !ex_valid |=> !q_valid && imem_addr == $past(dec_target));

    assert_hold_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !imem_gnt && !ex_valid && !dec_br_valid |=> $stable(imem_addr));

    assert_hold_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !imem_req && !ex_valid && !dec_br_valid |=> $stable(imem_addr));

    assert_spec_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && !dec_br_valid |=> !spec_active);
endmodule

bind fetch_unit fetch_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_fetch_unit.sv
`timescale 1ns/1ps
module tb_fetch_unit;
    localparam int unsigned AW = 32;
    localparam int unsigned IW = 32;
    localparam int unsigned DEPTH = 4;
    localparam logic [31:0] RPC = 32'h0000_0100;
    localparam logic [31:0] KEY = 32'hC0DE_0000;

    logic clk = 1'b0, rst_n = 1'b0, pred_mode = 1'b0;
    logic imem_req, imem_gnt = 1'b0;
    logic [AW-1:0] imem_addr;
    logic [IW-1:0] imem_rdata;
    logic q_valid, q_ready = 1'b0;
    logic [IW-1:0] q_instr;
    logic [AW-1:0] q_pc;
    logic dec_br_valid = 1'b0, dec_br_uncond = 1'b0, dec_hint_en = 1'b0, dec_hint = 1'b0;
    logic [AW-1:0] dec_pc = '0, dec_target = '0;
    logic dec_pred_taken;
    logic ex_valid = 1'b0, ex_taken = 1'b0, ex_pred_taken = 1'b0;
    logic [AW-1:0] ex_pc = '0, ex_target = '0;
    logic flush_dec, spec_active;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign imem_rdata = imem_addr ^ KEY;

    fetch_unit #(.AW(AW), .IW(IW), .DEPTH(DEPTH), .RESET_PC(RPC)) dut (.*);

    typedef struct packed {
        logic        mode;
        logic        unc;
        logic        hen;
        logic        hint;
        logic [31:0] pc;
        logic [31:0] tgt;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h100, 32'h040, 1'b0},  // R3 backward
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'h100, 32'h200, 1'b0},  // R3 forward
        '{1'b1, 1'b0, 1'b0, 1'b0, 32'h100, 32'h040, 1'b1},  // R4 backward
        '{1'b1, 1'b0, 1'b0, 1'b0, 32'h100, 32'h200, 1'b0},  // R4 forward
        '{1'b1, 1'b0, 1'b0, 1'b0, 32'h100, 32'h100, 1'b0},  // R4 equal
        '{1'b1, 1'b0, 1'b1, 1'b0, 32'h100, 32'h040, 1'b0},  // R5 hint over dir
        '{1'b0, 1'b0, 1'b1, 1'b1, 32'h100, 32'h200, 1'b1},  // R5 hint over default
        '{1'b0, 1'b1, 1'b0, 1'b0, 32'h100, 32'h200, 1'b1},  // R6
        '{1'b1, 1'b1, 1'b1, 1'b0, 32'h100, 32'h200, 1'b1}   // R6 hint ignored
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clr_br();
        dec_br_valid = 1'b0; dec_br_uncond = 1'b0; dec_hint_en = 1'b0; dec_hint = 1'b0;
        ex_valid = 1'b0; ex_taken = 1'b0; ex_pred_taken = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        chk(imem_addr == RPC, "R1 addr", imem_addr, RPC);
        chk(!q_valid, "R1 q_valid", 32'(q_valid), 0);
        chk(!spec_active, "R1 spec", 32'(spec_active), 0);

        // predictor table (R3 R4 R5 R6)
        for (int i = 0; i < 9; i++) begin
            pred_mode = VECS[i].mode; dec_br_uncond = VECS[i].unc;
            dec_hint_en = VECS[i].hen; dec_hint = VECS[i].hint;
            dec_pc = VECS[i].pc; dec_target = VECS[i].tgt;
            #1;
            chk(dec_pred_taken == VECS[i].exp, $sformatf("R3-6 vec %0d", i),
                32'(dec_pred_taken), 32'(VECS[i].exp));
        end
        clr_br(); pred_mode = 1'b0;

        // R10 no grant: address holds, nothing queued
        tick();
        chk(imem_addr == RPC, "R10 addr hold", imem_addr, RPC);
        chk(!q_valid, "R10 no push", 32'(q_valid), 0);

        // R2 fill
        imem_gnt = 1'b1;
        tick();
        chk(q_valid && q_pc == RPC, "R2 head pc", q_pc, RPC);
        chk(q_instr == (RPC ^ KEY), "R2 head instr", q_instr, RPC ^ KEY);
        chk(imem_addr == RPC + 4, "R2 advance", imem_addr, RPC + 4);
        repeat (DEPTH - 1) tick();
        chk(!imem_req, "R2 full stops req", 32'(imem_req), 0);
        tick();
        chk(imem_addr == RPC + 4 * DEPTH, "R2 full addr hold", imem_addr, RPC + 4 * DEPTH);

        // R11 in-order pops with concurrent pushes
        q_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            #0.5;
            chk(q_valid && q_pc == RPC + 4 * i, "R11 order pc", q_pc, RPC + 4 * i);
            chk(q_instr == ((RPC + 4 * i) ^ KEY), "R11 order instr", q_instr, (RPC + 4 * i) ^ KEY);
            tick();
        end
        q_ready = 1'b0;

        // R7 unconditional redirect from decode
        dec_br_valid = 1'b1; dec_br_uncond = 1'b1; dec_pc = 32'h104; dec_target = 32'h400;
        #1;
        chk(!q_valid, "R7 same-cycle gate", 32'(q_valid), 0);
        tick(); clr_br();
        chk(!q_valid, "R7 queue emptied", 32'(q_valid), 0);
        chk(imem_addr == 32'h400, "R7 target", imem_addr, 32'h400);
        tick();
        chk(q_valid && q_pc == 32'h400, "R7 target queued", q_pc, 32'h400);

        // R9 conditional predicted not taken: speculation, no redirect
        dec_br_valid = 1'b1; dec_pc = 32'h404; dec_target = 32'h800;
        tick(); clr_br();
        chk(spec_active, "R9 spec set", 32'(spec_active), 1);
        chk(imem_addr == 32'h408, "R3 no redirect", imem_addr, 32'h408);

        // R8 mispredict taken
        ex_valid = 1'b1; ex_taken = 1'b1; ex_pred_taken = 1'b0; ex_pc = 32'h404; ex_target = 32'h800;
        #1;
        chk(flush_dec, "R8 flush_dec", 32'(flush_dec), 1);
        chk(!q_valid, "R8 gate", 32'(q_valid), 0);
        tick(); clr_br();
        chk(!q_valid, "R8 queue emptied", 32'(q_valid), 0);
        chk(imem_addr == 32'h800, "R8 taken target", imem_addr, 32'h800);
        chk(!spec_active, "R9 spec cleared", 32'(spec_active), 0);

        // R8 not-taken mispredict beats decode redirect
        tick();
        ex_valid = 1'b1; ex_taken = 1'b0; ex_pred_taken = 1'b1; ex_pc = 32'h900; ex_target = 32'hA40;
        dec_br_valid = 1'b1; dec_br_uncond = 1'b1; dec_target = 32'hA00;
        tick(); clr_br();
        chk(imem_addr == 32'h904, "R8 priority fallthrough", imem_addr, 32'h904);

        // R8 correct prediction: no flush
        tick();
        ex_valid = 1'b1; ex_taken = 1'b1; ex_pred_taken = 1'b1; ex_pc = 32'h500; ex_target = 32'h600;
        #1;
        chk(!flush_dec, "R8 correct no flush", 32'(flush_dec), 0);
        chk(q_valid, "R8 correct queue kept", 32'(q_valid), 1);
        tick(); clr_br();
        chk(imem_addr == 32'h90C, "R8 correct no redirect", imem_addr, 32'h90C);

        // R4 backward redirect in direction mode
        pred_mode = 1'b1;
        dec_br_valid = 1'b1; dec_pc = 32'h908; dec_target = 32'h200;
        tick(); clr_br();
        chk(imem_addr == 32'h200, "R4 backward redirect", imem_addr, 32'h200);
        chk(spec_active, "R9 spec on taken cond", 32'(spec_active), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule